// File: doc/BRIEF.md
# Debounced Glitch-Free Clock Stop Controller

This block drives a bank of differential clock lanes from a reference clock that a faster system clock samples. Each lane has a true level, a complement level and a drive enable for each leg. An active-low stop request arrives with no timing relation to either clock. The block synchronises the request and debounces it on the complement clock. Lanes marked stoppable then park at a fixed level, and all of them restart together without a glitch. Lanes not marked keep running through the stop.

A mode bit chooses the parked state. In one mode the true leg stays driven high. In the other mode both legs are released low. An output-enable override releases every leg whatever else is happening. The lane mask and the mode bit are taken in only while no lane is stopped. A change made during a stop therefore takes effect at the next stop.

Top module: `clkstop_ctrl`

## Requirements
- R1: The complement clock is the inverse of `ref_clk_i`, so its rising edge is a falling edge of `ref_clk_i`. A new level on `stop_ni` is accepted only when it is seen at two consecutive complement rising edges. A low pulse shorter than one reference period never stops a lane.
- R2: A lane whose bit in `stoppable_i` is 0 (bit i belongs to lane i) keeps toggling with `lane_comp_o` equal to the inverse of `lane_true_o`. Both of its drive enables stay 1 while the override is low.
- R3: No high or low phase of any `lane_true_o` is shorter than half a reference period, whether the lane is stopping, parked or restarting.
- R4: With `park_float_i` = 0, a stopped lane shows `lane_true_o`=1, `true_en_o`=1, `lane_comp_o`=0 and `comp_en_o`=0.
- R5: With `park_float_i` = 1, a stopped lane shows 0 on its true level, its complement level and both of its drive enables.
- R6: After an accepted deassertion, all stopped lanes raise `comp_en_o` in the same cycle. This happens between 2 and 6 reference periods after `stop_ni` rises.
- R7: While `oe_force_i` = 1, every bit of `true_en_o` and `comp_en_o` is 0, in any state and any mode.
- R8: In the cycle before stopped lanes resume, each of them shows `lane_true_o`=1 with `true_en_o`=1. This also holds in mode 1.
- R9: Stopped lanes resume on a rising edge of the reference, so in the resume cycle every lane, stoppable or free, shows `lane_true_o`=1.
- R10: While `rst_ni` is low, and after it rises, every lane runs with both enables at 1. The debounce history is cleared to "not stopped".
- R11: Changes to `stoppable_i` and `park_float_i` made while any lane is stopped have no effect until every lane is running again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk_i |
| stop_ni | input | 1 | Active-low asynchronous stop request |
| stoppable_i | input | LANES | Per-lane stoppable mask |
| park_float_i | input | 1 | Park mode: 0 true driven high, 1 both released low |
| oe_force_i | input | 1 | Override that releases every leg |
| lane_true_o | output | LANES | True level per lane |
| lane_comp_o | output | LANES | Complement level per lane |
| true_en_o | output | LANES | True-leg drive enable per lane |
| comp_en_o | output | LANES | Complement-leg drive enable per lane |

## Verification
Two functions can act in the same cycle: the output-enable override and the stop/restart sequencing. The bench raises the override while lanes are parked and keeps it high through an entire restart. In every cycle it checks that all enables stay 0 while the lane levels still park, rise for the restart and toggle again. A second collision happens when the debounce sees a short stop pulse near a complement edge. The bench sweeps the start of a short pulse across every sampling phase of a reference period and checks that no enable ever drops.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ARMED  = 2'd1,
    ST_PARKED = 2'd2,
    ST_WAKE   = 2'd3
  } stop_state_e;

  typedef struct packed {
    logic lvl_t;
    logic lvl_c;
    logic en_t;
    logic en_c;
  } lane_drive_t;

  // Running lane: follows the sampled reference, both legs driven.
  function automatic lane_drive_t run_drive(input logic ref_lvl);
    lane_drive_t d;
    d.lvl_t = ref_lvl;
    d.lvl_c = ~ref_lvl;
    d.en_t  = 1'b1;
    d.en_c  = 1'b1;
    return d;
  endfunction

  // Parked lane: float=0 keeps the true leg driven high, float=1 releases both low.
  function automatic lane_drive_t park_drive(input logic float_mode);
    lane_drive_t d;
    d.lvl_t = ~float_mode;
    d.lvl_c = 1'b0;
    d.en_t  = ~float_mode;
    d.en_c  = 1'b0;
    return d;
  endfunction

  // Restart preparation: true leg driven high, complement still released.
  function automatic lane_drive_t wake_drive();
    lane_drive_t d;
    d.lvl_t = 1'b1;
    d.lvl_c = 1'b0;
    d.en_t  = 1'b1;
    d.en_c  = 1'b0;
    return d;
  endfunction

  // Debounced level: a new sample equal to the previous one is taken in.
  function automatic logic debounce_next(input logic cur_stop, input logic fresh_n,
                                         input logic prev_n);
    return (fresh_n == prev_n) ? ~fresh_n : cur_stop;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_debounce.sv
module clkstop_debounce
  import clkstop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_s_i,
  input  logic stop_s_i,
  output logic comp_rise_o,
  output logic ref_rise_o,
  output logic stop_acc_o
);
  logic ref_prev_q;
  logic sample_q;
  logic acc_q;

  // Complement rising edge == reference falling edge.
  assign comp_rise_o = ref_prev_q & ~ref_s_i;
  assign ref_rise_o  = ~ref_prev_q & ref_s_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ref_prev_q <= 1'b0;
      sample_q   <= 1'b1;
      acc_q      <= 1'b0;
    end else begin
      ref_prev_q <= ref_s_i;
      if (comp_rise_o) begin
        sample_q <= stop_s_i;
        acc_q    <= debounce_next(acc_q, stop_s_i, sample_q);
      end
    end
  end

  assign stop_acc_o = acc_q;
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int WAKE_RISES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_acc_i,
  input  logic             comp_rise_i,
  input  logic             ref_rise_i,
  input  logic [LANES-1:0] stoppable_i,
  input  logic             park_float_i,
  output stop_state_e      state_o,
  output logic [LANES-1:0] mask_o,
  output logic             float_o
);
  localparam int CW = $clog2(WAKE_RISES + 1);
  localparam logic [CW-1:0] LAST_RISE = CW'(WAKE_RISES - 1);

  stop_state_e      state_q;
  logic [CW-1:0]    rise_cnt_q;
  logic [LANES-1:0] mask_q;
  logic             float_q;
  logic             park_edge;

  // Mode 0 parks on the edge that makes true high, mode 1 on the edge making it low.
  assign park_edge = float_q ? comp_rise_i : ref_rise_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      rise_cnt_q <= '0;
      mask_q     <= '0;
      float_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          mask_q  <= stoppable_i;
          float_q <= park_float_i;
          if (stop_acc_i) state_q <= ST_ARMED;
        end
        ST_ARMED: begin
          if (!stop_acc_i)    state_q <= ST_RUN;
          else if (park_edge) state_q <= ST_PARKED;
        end
        ST_PARKED: begin
          if (!stop_acc_i) begin
            state_q    <= ST_WAKE;
            rise_cnt_q <= '0;
          end
        end
        ST_WAKE: begin
          if (ref_rise_i) begin
            if (rise_cnt_q == LAST_RISE) state_q <= ST_RUN;
            else                         rise_cnt_q <= rise_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = state_q;
  assign mask_o  = mask_q;
  assign float_o = float_q;
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
(
  input  logic ref_lvl_i,
  input  logic parked_i,
  input  logic wake_i,
  input  logic stoppable_i,
  input  logic float_i,
  input  logic oe_force_i,
  output logic true_o,
  output logic comp_o,
  output logic true_en_o,
  output logic comp_en_o
);
  lane_drive_t drv;

  always_comb begin
    drv = run_drive(ref_lvl_i);
    if (stoppable_i && parked_i)    drv = park_drive(float_i);
    else if (stoppable_i && wake_i) drv = wake_drive();
    true_o    = drv.lvl_t;
    comp_o    = drv.lvl_c;
    true_en_o = drv.en_t & ~oe_force_i;
    comp_en_o = drv.en_c & ~oe_force_i;
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_RISES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             stop_ni,
  input  logic [LANES-1:0] stoppable_i,
  input  logic             park_float_i,
  input  logic             oe_force_i,
  output logic [LANES-1:0] lane_true_o,
  output logic [LANES-1:0] lane_comp_o,
  output logic [LANES-1:0] true_en_o,
  output logic [LANES-1:0] comp_en_o
);
  logic             ref_s_w;
  logic             stop_sync_w;
  logic             comp_rise_w;
  logic             ref_rise_w;
  logic             stop_acc_w;
  stop_state_e      state_w;
  logic [LANES-1:0] mask_w;
  logic             float_w;
  logic             parked_w;
  logic             wake_w;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ref_clk_i), .q_o(ref_s_w));

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_ni), .q_o(stop_sync_w));

  clkstop_debounce u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_s_i(ref_s_w), .stop_s_i(stop_sync_w),
    .comp_rise_o(comp_rise_w), .ref_rise_o(ref_rise_w), .stop_acc_o(stop_acc_w));

  clkstop_seq #(.LANES(LANES), .WAKE_RISES(WAKE_RISES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_acc_i(stop_acc_w),
    .comp_rise_i(comp_rise_w), .ref_rise_i(ref_rise_w),
    .stoppable_i(stoppable_i), .park_float_i(park_float_i),
    .state_o(state_w), .mask_o(mask_w), .float_o(float_w));

  assign parked_w = (state_w == ST_PARKED);
  assign wake_w   = (state_w == ST_WAKE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    clkstop_lane u_lane (
      .ref_lvl_i(ref_s_w), .parked_i(parked_w), .wake_i(wake_w),
      .stoppable_i(mask_w[g]), .float_i(float_w), .oe_force_i(oe_force_i),
      .true_o(lane_true_o[g]), .comp_o(lane_comp_o[g]),
      .true_en_o(true_en_o[g]), .comp_en_o(comp_en_o[g]));
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk
  import clkstop_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_force_i,
  input logic [LANES-1:0] lane_true_o,
  input logic [LANES-1:0] lane_comp_o,
  input logic [LANES-1:0] true_en_o,
  input logic [LANES-1:0] comp_en_o,
  input logic             comp_rise_w,
  input logic             stop_acc_w,
  input stop_state_e      state_w,
  input logic [LANES-1:0] mask_w,
  input logic             float_w
);
  logic parked, wake, busy;
  assign parked = (state_w == ST_PARKED);
  assign wake   = (state_w == ST_WAKE);
  assign busy   = (state_w != ST_RUN);

  // R1: the accepted level only moves just after a complement rising edge
  assert_accept_on_comp_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_acc_w) |-> $past(comp_rise_w));

  // R2: free-running lanes stay driven and complementary
  assert_free_lane_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_force_i |-> (((~mask_w) & ~(true_en_o & comp_en_o)) == '0)
                    && (((~mask_w) & ~(lane_true_o ^ lane_comp_o)) == '0));

  // R4: driven-high park
  assert_park_driven_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !float_w && !oe_force_i) |->
      ((lane_true_o & mask_w) == mask_w) && ((true_en_o & mask_w) == mask_w)
      && ((comp_en_o & mask_w) == '0) && ((lane_comp_o & mask_w) == '0));

  // R5: released-low park
  assert_park_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && float_w) |->
      ((lane_true_o & mask_w) == '0) && ((true_en_o & mask_w) == '0)
      && ((comp_en_o & mask_w) == '0) && ((lane_comp_o & mask_w) == '0));

  // R7: override releases every leg
  assert_oe_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_force_i |-> (true_en_o == '0) && (comp_en_o == '0));

  // R8: true leg driven high before restart
  assert_wake_true_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !oe_force_i) |->
      ((lane_true_o & mask_w) == mask_w) && ((true_en_o & mask_w) == mask_w));

  // R9 / R6: every lane high in the first running cycle after restart
  assert_resume_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake) && !wake) |-> (lane_true_o == '1));

  // R11: configuration frozen while any lane is stopped
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(mask_w) && $stable(float_w));
endmodule

bind clkstop_ctrl clkstop_chk #(.LANES(LANES)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .oe_force_i(oe_force_i),
  .lane_true_o(lane_true_o), .lane_comp_o(lane_comp_o),
  .true_en_o(true_en_o), .comp_en_o(comp_en_o),
  .comp_rise_w(comp_rise_w), .stop_acc_w(stop_acc_w), .state_w(state_w),
  .mask_w(mask_w), .float_w(float_w));

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
  localparam int LANES  = 3;
  localparam int HALF   = 4;          // system cycles per reference half period
  localparam int PERIOD = 2 * HALF;

  logic clk = 1'b0;
  always #4 clk = ~clk;               // 125 MHz

  logic             rst_n = 1'b0;
  logic             ref_clk = 1'b0;
  logic             stop_n = 1'b1;
  logic [LANES-1:0] stoppable = '0;
  logic             park_float = 1'b0;
  logic             oe_force = 1'b0;
  logic [LANES-1:0] lane_true, lane_comp, true_en, comp_en;

  int n_chk  = 0;
  int n_fail = 0;
  int glitches = 0;
  bit mon_on = 1'b0;
  int run_len [LANES];
  logic [LANES-1:0] last_true;
  int wd = 0;

  clkstop_ctrl #(.LANES(LANES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .stop_ni(stop_n),
    .stoppable_i(stoppable), .park_float_i(park_float), .oe_force_i(oe_force),
    .lane_true_o(lane_true), .lane_comp_o(lane_comp),
    .true_en_o(true_en), .comp_en_o(comp_en));

  initial forever begin
    repeat (HALF) @(negedge clk);
    ref_clk = ~ref_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R3: pulse-width monitor on every lane's true level
  always @(negedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!mon_on) run_len[i] = HALF;
      else if (lane_true[i] != last_true[i]) begin
        if (run_len[i] < HALF) glitches++;
        run_len[i] = 1;
      end else run_len[i] = run_len[i] + 1;
    end
    last_true = lane_true;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL WATCHDOG actual=%0d expected=%0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Expected drive of one lane in the parked state (R4/R5) or running (R2)
  task automatic check_parked(input logic [LANES-1:0] mask, input logic mode);
    for (int i = 0; i < LANES; i++) begin
      logic [3:0] act, exp;
      act = {lane_true[i], lane_comp[i], true_en[i], comp_en[i]};
      if (mask[i]) begin
        exp = mode ? 4'b0000 : 4'b1010;
        check(act == exp, mode ? "R5 released park" : "R4 driven park", act, exp);
      end else begin
        check(true_en[i] && comp_en[i] && (lane_true[i] != lane_comp[i]),
              "R2 free lane during stop", act, {lane_true[i], ~lane_true[i], 2'b11});
      end
    end
  endtask

  task automatic do_stop();
    stop_n = 1'b0;
    wait_cyc(5 * PERIOD);
  endtask

  // Release the stop and check the restart (R6, R8, R9)
  task automatic do_resume(input logic [LANES-1:0] mask);
    int lat = 0;
    bit done = 1'b0;
    logic [LANES-1:0] prev_t, prev_te;
    stop_n = 1'b1;
    prev_t = lane_true; prev_te = true_en;
    while (!done && lat < 120) begin
      prev_t = lane_true; prev_te = true_en;
      @(negedge clk);
      lat++;
      if (mask == '0 || (comp_en & mask) != '0) done = 1'b1;
    end
    if (mask != '0) begin
      check((comp_en & mask) == mask, "R6 lanes resume together", comp_en, mask);
      check(lat >= 2 * PERIOD && lat <= 6 * PERIOD, "R6 restart latency", lat, 4 * PERIOD);
      check(lane_true == '1, "R9 resume on high phase in step", lane_true, '1);
      check(((prev_t & prev_te) & mask) == mask, "R8 true driven high before resume",
            prev_t & prev_te, mask);
    end
    wait_cyc(2 * PERIOD);
  endtask

  initial begin
    // R10: reset state
    wait_cyc(6);
    check(true_en == '1 && comp_en == '1, "R10 enables during reset", {true_en, comp_en}, '1);
    rst_n = 1'b1;
    wait_cyc(3 * PERIOD);
    check(true_en == '1 && comp_en == '1, "R10 enables after reset", {true_en, comp_en}, '1);
    check((lane_true ^ lane_comp) == '1, "R10 lanes running after reset", lane_true ^ lane_comp, '1);
    mon_on = 1'b1;

    // Sweep every mask in both park modes
    for (int md = 0; md < 2; md++) begin
      for (int m = 0; m < (1 << LANES); m++) begin
        int toggles = 0;
        logic [LANES-1:0] prv;
        stoppable  = LANES'(m);
        park_float = md[0];
        wait_cyc(PERIOD);
        do_stop();
        check_parked(LANES'(m), md[0]);
        prv = lane_true;
        for (int c = 0; c < 4 * PERIOD; c++) begin
          @(negedge clk);
          if ((lane_true ^ prv) & ~LANES'(m)) toggles++;
          prv = lane_true;
        end
        if (m != (1 << LANES) - 1)
          check(toggles >= 7, "R2 free lanes keep toggling", toggles, 8);
        do_resume(LANES'(m));
      end
    end

    // R1: short stop pulses at every sampling phase are rejected
    stoppable = '1; park_float = 1'b0;
    wait_cyc(PERIOD);
    for (int off = 0; off < PERIOD; off++) begin
      bit dropped = 1'b0;
      wait_cyc(off);
      stop_n = 1'b0;
      wait_cyc(3);
      stop_n = 1'b1;
      for (int c = 0; c < 5 * PERIOD; c++) begin
        @(negedge clk);
        if (comp_en != '1) dropped = 1'b1;
      end
      check(!dropped, "R1 short pulse ignored", dropped, 0);
    end

    // R11: reconfiguration during a stop has no effect until restart
    stoppable = 3'b001; park_float = 1'b0;
    wait_cyc(PERIOD);
    do_stop();
    stoppable = 3'b110; park_float = 1'b1;
    wait_cyc(3 * PERIOD);
    check_parked(3'b001, 1'b0);
    check({lane_true[0], true_en[0]} == 2'b11, "R11 old config kept while stopped",
          {lane_true[0], true_en[0]}, 2'b11);
    do_resume(3'b001);
    do_stop();
    check_parked(3'b110, 1'b1);
    check(true_en[0] && comp_en[0], "R11 new config after restart", {true_en[0], comp_en[0]}, 2'b11);
    do_resume(3'b110);

    // R7: override while running, while parked and across a whole restart
    stoppable = 3'b011; park_float = 1'b0;
    wait_cyc(PERIOD);
    oe_force = 1'b1;
    wait_cyc(1);
    check(true_en == '0 && comp_en == '0, "R7 override while running", {true_en, comp_en}, 0);
    stop_n = 1'b0;
    wait_cyc(5 * PERIOD);
    check(true_en == '0 && comp_en == '0, "R7 override while parked", {true_en, comp_en}, 0);
    check((lane_true & 3'b011) == 3'b011, "R4 level kept under override", lane_true, 3'b011);
    begin
      bit leaked = 1'b0;
      int tg = 0;
      logic p0;
      stop_n = 1'b1;
      p0 = lane_true[0];
      for (int c = 0; c < 8 * PERIOD; c++) begin
        @(negedge clk);
        if (true_en != '0 || comp_en != '0) leaked = 1'b1;
        if (lane_true[0] != p0) tg++;
        p0 = lane_true[0];
      end
      check(!leaked, "R7 override across restart", leaked, 0);
      check(tg >= 6, "R6 lane restarts under override", tg, 8);
    end
    oe_force = 1'b0;
    wait_cyc(2);
    check(true_en == '1 && comp_en == '1, "R7 override released", {true_en, comp_en}, '1);

    check(glitches == 0, "R3 no shortened phase", glitches, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule